// File: doc/BRIEF.md
# Descriptor Ring Request Engine

This block moves requests between a host and a processing back end through two circular lists held in local RAMs. The host writes descriptors into the inbound list. Each descriptor holds a request's physical address and its byte size. The host then moves a write pointer to the index of the last unit it filled. The engine hands those descriptors to the back end one at a time, in ring order, over a valid/ready fetch port.

When the back end reports a finished request, the engine writes the request's flag, ORed with a fixed host-marker mask, into the next unit of the outbound list. It then publishes that unit's index in a shadow pointer and latches an interrupt cause. The host keeps its own saved read pointer N. While the shadow differs from N, the host reads unit N+1, wrapping as needed.

A separate command/reply message pair carries non-queued commands. The host writes a command word, and the back end answers by loading a reply word. The command is done when the reply equals the command. The base-address registers are storage for the host only. All list accesses go to the local RAMs.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `req_valid` is 0.
- R2: The base registers read back the last value written to them: inbound low/high at 0x4000/0x4004, outbound low/high at 0x4050/0x4054, and shadow base low/high at 0x4058/0x405C.
- R3: The control register at 0x402C holds the enable in bit 0 and the ring count in bits [12:8]. A count of 0, or a count above DEPTH, is stored as DEPTH. On a write that sets enable while the engine is disabled, the write pointer (0x4018), the consumed index and the shadow pointer (read at 0x4060) all become count-1. While enable is set, writes to the count are ignored.
- R4: Starting from the unit after the last consumed one, the engine presents inbound units in order, up to and including the write pointer. `req_valid` is low when the consumed index equals the write pointer. A unit is consumed on a cycle with `req_valid` and `req_ready` both high.
- R5: Inbound unit i stores its address word at 0x1000+8i and its size word at 0x1004+8i. The fetch port shows the address with bits [4:0] forced to zero, since requests are 32-byte aligned.
- R6: Every ring index (inbound consumed, outbound shadow) steps from count-1 back to 0.
- R7: On a cycle where the engine is enabled and `cpl_valid` is high, `cpl_flag | 0x80000000` is written to outbound unit shadow+1, wrapping. That unit reads at 0x2000+4i, and the shadow pointer takes its index.
- R8: Bit 0 of the cause register (0x4088) is set by each completion and cleared by writing 1 to it. A completion in the same cycle as the clear leaves it set.
- R9: `irq` is high exactly when cause bit 0 and enable bit 0 (0x408C) are both set.
- R10: A write to 0x0400 loads `msg_cmd` and raises `msg_cmd_new` for one cycle. `msg_reply_we` loads `msg_reply` into the register read at 0x0420.
- R11: While the engine is disabled, `req_valid` stays low and completions change neither the shadow pointer nor the outbound list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address, used for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| req_valid | output | 1 | A descriptor is offered to the back end |
| req_ready | input | 1 | The back end takes the offered descriptor |
| req_idx | output | 4 | Inbound unit index of the offered descriptor |
| req_addr | output | 32 | Request address, 32-byte aligned |
| req_size | output | 32 | Request size |
| cpl_valid | input | 1 | The back end reports a finished request |
| cpl_flag | input | 32 | Flag of the finished request |
| irq | output | 1 | Outbound interrupt |
| msg_cmd | output | 32 | Last command word from the host |
| msg_cmd_new | output | 1 | One-cycle pulse when a new command is written |
| msg_reply_we | input | 1 | Load strobe for the reply word |
| msg_reply | input | 32 | Reply word from the back end |

## Verification
The fetch port is driven three ways. With a stalled ready, the bench sees that the offered unit is held and the low address bits are masked. With a ready held high across several units, it sees that the order is kept and that the engine stops exactly at the write pointer. With a write pointer that lands past the ring end, it sees that the index wraps to zero. Completions are issued first with the interrupt disabled, then with it enabled, and then in the same cycle as a cause clear. These runs separate the wrap of the outbound index, the gating of `irq`, and the rule that a set beats a clear. A final group of cases covers writes that must be ignored: a count change while the engine is enabled, and completions while it is disabled.

// File: rtl/desc_ring_engine.sv
module desc_ring_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter logic [DW-1:0] HOST_MARK = 32'h8000_0000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [$clog2(DEPTH)-1:0] req_idx,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_size,
  input  logic          cpl_valid,
  input  logic [DW-1:0] cpl_flag,
  output logic          irq,
  output logic [DW-1:0] msg_cmd,
  output logic          msg_cmd_new,
  input  logic          msg_reply_we,
  input  logic [DW-1:0] msg_reply
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam logic [AW-1:0] A_IB_LO = AW'(16'h4000), A_IB_HI = AW'(16'h4004);
  localparam logic [AW-1:0] A_WP    = AW'(16'h4018), A_CFG   = AW'(16'h402C);
  localparam logic [AW-1:0] A_OB_LO = AW'(16'h4050), A_OB_HI = AW'(16'h4054);
  localparam logic [AW-1:0] A_SB_LO = AW'(16'h4058), A_SB_HI = AW'(16'h405C);
  localparam logic [AW-1:0] A_SHV   = AW'(16'h4060);
  localparam logic [AW-1:0] A_CAUSE = AW'(16'h4088), A_IEN   = AW'(16'h408C);
  localparam logic [AW-1:0] A_MSG   = AW'(16'h0400), A_REP   = AW'(16'h0420);
  localparam logic [AW-1:0] IB_BASE = AW'(16'h1000), OB_BASE = AW'(16'h2000);

  logic [DW-1:0] ib_lo, ib_hi, ob_lo, ob_hi, sb_lo, sb_hi, msg_rep;
  logic          en, cause, ien;
  logic [CW-1:0] cnt;
  logic [IW-1:0] wp, cons, shadow;
  logic [DW-1:0] ib_addr [DEPTH];
  logic [DW-1:0] ib_size [DEPTH];
  logic [DW-1:0] ob_ent  [DEPTH];

  logic [IW-1:0] nidx, oidx, ib_sel, ob_sel;
  logic [CW-1:0] wcnt, lcnt;
  logic          in_ib, in_ob;

  assign nidx   = (CW'(cons) == cnt - CW'(1)) ? '0 : cons + IW'(1);
  assign oidx   = (CW'(shadow) == cnt - CW'(1)) ? '0 : shadow + IW'(1);
  assign wcnt   = bus_wdata[8 +: CW];
  assign lcnt   = (wcnt == '0 || wcnt > CW'(DEPTH)) ? CW'(DEPTH) : wcnt;
  assign in_ib  = bus_addr >= IB_BASE && bus_addr < IB_BASE + AW'(DEPTH * 8);
  assign in_ob  = bus_addr >= OB_BASE && bus_addr < OB_BASE + AW'(DEPTH * 4);
  assign ib_sel = bus_addr[3 +: IW];
  assign ob_sel = bus_addr[2 +: IW];

  assign req_valid = en && (cons != wp);
  assign req_idx   = nidx;
  assign req_addr  = {ib_addr[nidx][DW-1:5], 5'b0};
  assign req_size  = ib_size[nidx];
  assign irq       = cause & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ib_lo, ib_hi, ob_lo, ob_hi, sb_lo, sb_hi} <= '0;
      {en, cause, ien, msg_cmd_new} <= '0;
      cnt <= '0; wp <= '0; cons <= '0; shadow <= '0;
      msg_cmd <= '0; msg_rep <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ib_addr[i] <= '0; ib_size[i] <= '0; ob_ent[i] <= '0;
      end
    end else begin
      msg_cmd_new <= 1'b0;
      if (bus_we) begin
        case (bus_addr)
          A_IB_LO: ib_lo <= bus_wdata;
          A_IB_HI: ib_hi <= bus_wdata;
          A_OB_LO: ob_lo <= bus_wdata;
          A_OB_HI: ob_hi <= bus_wdata;
          A_SB_LO: sb_lo <= bus_wdata;
          A_SB_HI: sb_hi <= bus_wdata;
          A_WP:    wp <= bus_wdata[IW-1:0];
          A_CFG: begin
            en <= bus_wdata[0];
            if (!en) begin
              cnt <= lcnt;
              if (bus_wdata[0]) begin
                wp <= IW'(lcnt - CW'(1));
                cons <= IW'(lcnt - CW'(1));
                shadow <= IW'(lcnt - CW'(1));
              end
            end
          end
          A_CAUSE: if (bus_wdata[0]) cause <= 1'b0;
          A_IEN:   ien <= bus_wdata[0];
          A_MSG: begin
            msg_cmd <= bus_wdata;
            msg_cmd_new <= 1'b1;
          end
          default: ;
        endcase
        if (in_ib) begin
          if (bus_addr[2]) ib_size[ib_sel] <= bus_wdata;
          else             ib_addr[ib_sel] <= bus_wdata;
        end
      end
      if (req_valid && req_ready) cons <= nidx;
      if (en && cpl_valid) begin
        ob_ent[oidx] <= cpl_flag | HOST_MARK;
        shadow <= oidx;
        cause <= 1'b1;
      end
      if (msg_reply_we) msg_rep <= msg_reply;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_IB_LO: bus_rdata = ib_lo;
      A_IB_HI: bus_rdata = ib_hi;
      A_OB_LO: bus_rdata = ob_lo;
      A_OB_HI: bus_rdata = ob_hi;
      A_SB_LO: bus_rdata = sb_lo;
      A_SB_HI: bus_rdata = sb_hi;
      A_WP:    bus_rdata = DW'(wp);
      A_CFG: begin
        bus_rdata[0] = en;
        bus_rdata[8 +: CW] = cnt;
      end
      A_SHV:   bus_rdata = DW'(shadow);
      A_CAUSE: bus_rdata = DW'(cause);
      A_IEN:   bus_rdata = DW'(ien);
      A_MSG:   bus_rdata = msg_cmd;
      A_REP:   bus_rdata = msg_rep;
      default: ;
    endcase
    if (in_ib) bus_rdata = bus_addr[2] ? ib_size[ib_sel] : ib_addr[ib_sel];
    if (in_ob) bus_rdata = ob_ent[ob_sel];
  end
endmodule

// File: rtl/desc_ring_engine_chk.sv
module desc_ring_engine_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int CW = 5
)(
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [CW-1:0] cnt,
  input logic [IW-1:0] cons,
  input logic [IW-1:0] shadow,
  input logic [IW-1:0] oidx,
  input logic          cause,
  input logic          ien,
  input logic          irq,
  input logic          req_valid,
  input logic          req_ready,
  input logic [IW-1:0] req_idx,
  input logic          cpl_valid,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] msg_cmd,
  input logic          msg_cmd_new
);
  assert_count_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (!en || cnt == $past(cnt)));
  assert_fetch_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cons == $past(req_idx)));
  assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (CW'(cons) < cnt && CW'(shadow) < cnt));
  assert_shadow_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cpl_valid) |=> (shadow == $past(oidx)));
  assert_cause_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cpl_valid) |=> cause);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
  assert_msg_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(16'h0400)) |=> (msg_cmd_new && msg_cmd == $past(bus_wdata)));
  assert_idle_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !req_valid);
endmodule

bind desc_ring_engine desc_ring_engine_chk #(.AW(AW), .DW(DW), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .cons(cons), .shadow(shadow),
  .oidx(oidx), .cause(cause), .ien(ien), .irq(irq), .req_valid(req_valid),
  .req_ready(req_ready), .req_idx(req_idx), .cpl_valid(cpl_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .msg_cmd(msg_cmd), .msg_cmd_new(msg_cmd_new)
);

// File: tb/desc_ring_engine_tb.sv
`timescale 1ns/100ps
module desc_ring_engine_tb;
  logic clk = 0, rst_n = 0, bus_we = 0, req_ready = 0, cpl_valid = 0, msg_reply_we = 0;
  logic [15:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, cpl_flag = 0, msg_reply = 0;
  logic [31:0] bus_rdata, req_addr, req_size, msg_cmd;
  logic [3:0]  req_idx;
  logic        req_valid, irq, msg_cmd_new;

  desc_ring_engine u_dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0, live = 0;

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // reference model
  int m_en, m_cnt, m_wp, m_cons, m_sh, m_cause, m_ien, m_new;
  int m_lc, m_nc, m_ns, m_old_en;
  bit m_fire, m_cpl;
  logic [31:0] m_msg, m_rep;
  logic [31:0] m_reg [6];
  logic [31:0] m_iba [16], m_ibs [16], m_ob [16];

  function automatic int step(int x);
    return (x == m_cnt - 1) ? 0 : x + 1;
  endfunction

  function automatic logic [31:0] m_rd(logic [15:0] a);
    if (a >= 16'h1000 && a < 16'h1080) return a[2] ? m_ibs[a[6:3]] : m_iba[a[6:3]];
    if (a >= 16'h2000 && a < 16'h2040) return m_ob[a[5:2]];
    case (a)
      16'h4000: return m_reg[0];
      16'h4004: return m_reg[1];
      16'h4050: return m_reg[2];
      16'h4054: return m_reg[3];
      16'h4058: return m_reg[4];
      16'h405C: return m_reg[5];
      16'h4018: return 32'(m_wp);
      16'h402C: return 32'(m_en) | (32'(m_cnt) << 8);
      16'h4060: return 32'(m_sh);
      16'h4088: return 32'(m_cause);
      16'h408C: return 32'(m_ien);
      16'h0400: return m_msg;
      16'h0420: return m_rep;
      default:  return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cnt = 0; m_wp = 0; m_cons = 0; m_sh = 0; m_cause = 0; m_ien = 0; m_new = 0;
      m_msg = 0; m_rep = 0;
      for (int i = 0; i < 6; i++) m_reg[i] = 0;
      for (int i = 0; i < 16; i++) begin m_iba[i] = 0; m_ibs[i] = 0; m_ob[i] = 0; end
    end else begin
      m_fire = m_en != 0 && m_cons != m_wp && req_ready;
      m_cpl = m_en != 0 && cpl_valid;
      m_nc = step(m_cons); m_ns = step(m_sh); m_old_en = m_en;
      m_new = 0;
      if (bus_we) begin
        case (bus_addr)
          16'h4000: m_reg[0] = bus_wdata;
          16'h4004: m_reg[1] = bus_wdata;
          16'h4050: m_reg[2] = bus_wdata;
          16'h4054: m_reg[3] = bus_wdata;
          16'h4058: m_reg[4] = bus_wdata;
          16'h405C: m_reg[5] = bus_wdata;
          16'h4018: m_wp = int'(bus_wdata[3:0]);
          16'h402C: begin
            m_lc = int'(bus_wdata[12:8]);
            if (m_lc == 0 || m_lc > 16) m_lc = 16;
            if (m_old_en == 0) begin
              m_cnt = m_lc;
              if (bus_wdata[0]) begin m_wp = m_lc - 1; m_cons = m_lc - 1; m_sh = m_lc - 1; end
            end
            m_en = int'(bus_wdata[0]);
          end
          16'h4088: if (bus_wdata[0]) m_cause = 0;
          16'h408C: m_ien = int'(bus_wdata[0]);
          16'h0400: begin m_msg = bus_wdata; m_new = 1; end
          default: ;
        endcase
        if (bus_addr >= 16'h1000 && bus_addr < 16'h1080) begin
          if (bus_addr[2]) m_ibs[bus_addr[6:3]] = bus_wdata;
          else             m_iba[bus_addr[6:3]] = bus_wdata;
        end
      end
      if (m_fire) m_cons = m_nc;
      if (m_cpl) begin m_ob[m_ns] = cpl_flag | 32'h8000_0000; m_sh = m_ns; m_cause = 1; end
      if (msg_reply_we) m_rep = msg_reply;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R4 req_valid", req_valid, (m_en != 0 && m_cons != m_wp));
      if (m_en != 0 && m_cons != m_wp) begin
        chk("R6 req_idx", req_idx, step(m_cons));
        chk("R5 req_addr", req_addr, m_iba[step(m_cons)] & 32'hFFFF_FFE0);
        chk("R5 req_size", req_size, m_ibs[step(m_cons)]);
      end
      chk("R9 irq", irq, m_cause & m_ien);
      chk("R10 msg_cmd", msg_cmd, m_msg);
      chk("R10 msg_cmd_new", msg_cmd_new, m_new);
      chk("R2 bus_rdata", bus_rdata, m_rd(bus_addr));
    end
  end

  task automatic wr(logic [15:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rdchk(logic [15:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic cpl(logic [31:0] f);
    cpl_valid = 1; cpl_flag = f;
    @(posedge clk); #1;
    cpl_valid = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; live = 1;
    // R1 reset state
    rdchk(16'h402C, 0, "R1 cfg");
    chk("R1 irq", irq, 0);
    chk("R1 req_valid", req_valid, 0);
    rdchk(16'h4060, 0, "R1 shadow");
    // R2 base registers
    wr(16'h4000, 32'h1111_0000); wr(16'h4004, 32'h2222); wr(16'h4050, 32'h3333_0000);
    wr(16'h4054, 32'h4444); wr(16'h4058, 32'h5555_0040); wr(16'h405C, 32'h6666);
    rdchk(16'h4000, 32'h1111_0000, "R2 ib_lo");
    rdchk(16'h4054, 32'h4444, "R2 ob_hi");
    rdchk(16'h405C, 32'h6666, "R2 sb_hi");
    // R5 descriptors with unaligned low bits
    for (int i = 0; i < 5; i++) begin
      wr(16'(16'h1000 + 8 * i), 32'h1000_0000 + 32'(i) * 32'h100 + 32'h13);
      wr(16'(16'h1004 + 8 * i), 32'(64 * (i + 1)));
    end
    rdchk(16'h1008, 32'h1000_0113, "R5 unit1 addr word");
    // R3 enable with count 5
    wr(16'h402C, (32'd5 << 8) | 32'd1);
    rdchk(16'h4018, 4, "R3 wp init");
    rdchk(16'h4060, 4, "R3 shadow init");
    // R4 stalled fetch
    wr(16'h4018, 1);
    @(negedge clk);
    chk("R4 valid", req_valid, 1);
    chk("R4 idx", req_idx, 0);
    chk("R5 aligned addr", req_addr, 32'h1000_0000);
    chk("R5 size", req_size, 64);
    req_ready = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 stop at wp", req_valid, 0);
    wr(16'h4018, 4);
    repeat (4) @(posedge clk);
    #1 req_ready = 0;
    // R6 write pointer wraps to unit 0
    wr(16'h4018, 0);
    @(negedge clk);
    chk("R6 wrap valid", req_valid, 1);
    chk("R6 wrap idx", req_idx, 0);
    req_ready = 1;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R6 drained", req_valid, 0);
    @(posedge clk); #1;
    // R7 completions with interrupt masked
    for (int k = 0; k < 6; k++) cpl(32'h10 + 32'(k));
    rdchk(16'h4060, 0, "R6 shadow wrap");
    rdchk(16'h2000, 32'h8000_0015, "R7 unit0 entry");
    rdchk(16'h2010, 32'h8000_0014, "R7 unit4 entry");
    chk("R9 masked irq", irq, 0);
    rdchk(16'h4088, 1, "R8 cause set");
    wr(16'h408C, 1);
    @(negedge clk);
    chk("R9 irq on", irq, 1);
    @(posedge clk); #1;
    // R8 set beats clear
    bus_we = 1; bus_addr = 16'h4088; bus_wdata = 1; cpl_valid = 1; cpl_flag = 32'h20;
    @(posedge clk); #1;
    bus_we = 0; cpl_valid = 0;
    rdchk(16'h4088, 1, "R8 set wins");
    rdchk(16'h2004, 32'h8000_0020, "R7 unit1 entry");
    wr(16'h4088, 1);
    rdchk(16'h4088, 0, "R8 cleared");
    chk("R9 irq off", irq, 0);
    // R3 count frozen while enabled
    wr(16'h402C, (32'd3 << 8) | 32'd1);
    rdchk(16'h402C, (32'd5 << 8) | 32'd1, "R3 count frozen");
    // R11 disabled engine ignores completions
    wr(16'h402C, 0);
    cpl(32'h77);
    rdchk(16'h4060, 1, "R11 shadow held");
    rdchk(16'h2008, 32'h8000_0012, "R11 entry held");
    chk("R11 no fetch", req_valid, 0);
    // R3 count 0 legalised to DEPTH
    wr(16'h402C, 1);
    rdchk(16'h402C, (32'd16 << 8) | 32'd1, "R3 count zero");
    rdchk(16'h4018, 15, "R3 wp at depth");
    // R10 message pair
    wr(16'h0400, 32'hA5);
    @(negedge clk);
    chk("R10 pulse", msg_cmd_new, 1);
    chk("R10 cmd", msg_cmd, 32'hA5);
    @(posedge clk); #1;
    chk("R10 one cycle", msg_cmd_new, 0);
    msg_reply_we = 1; msg_reply = 32'hA5;
    @(posedge clk); #1;
    msg_reply_we = 0;
    rdchk(16'h0420, 32'hA5, "R10 reply");
    done = 1;
    report();
  end
endmodule